// File: doc/BRIEF.md
# Dual-Port Address-Collision Arbiter

This block sits in front of a shared 2048 x 8 memory that two independent agents, left and right, use at the same time. Each side has an active-low enable, a read/write select (low means write), an active-low output enable, an 11-bit address and a write data bus. Reads from both sides may hit the same word in the same cycle. When both sides are enabled on one address, the arbiter gives the word to one side. It drives an active-low busy flag toward the other side and drops that side's write. A dropped write is not queued, so the requester retries once its busy flag clears.

Ownership goes to the side whose enable and address were already stable in the previous cycle while the other side's were not. When both arrive in the same cycle, the left side wins. Ownership then holds for as long as the collision lasts. While a losing side keeps reading the contested word, its read data stays frozen. It picks up the new contents once busy clears, its address or enable changes, or it switches between write and read. A build parameter selects a slave variant. In that variant the busy pins are inputs that block writes, and the busy outputs stay high. Several slaves can then follow one master to build wider words.

Top module: `dpc_arbiter_top`

## Requirements
- R1: After reset both busy outputs are high, and read data is 0x00 on a side whose output enable is low.
- R2: A write takes place at a clock edge when the side's enable and write select are both low and the side does not lose. Read data is registered: a side that is enabled with write select high shows the stored word after the next clock edge. Both sides may read the same word in the same cycle.
- R3: A side whose output enable is high shows read data 0x00.
- R4: In master mode, when both sides become enabled on the same address in the same cycle (neither was stable there before), the left side wins. After that edge right busy is low and left busy is high, and the right write of that cycle is dropped.
- R5: In master mode, a side whose enable and address were unchanged and active since the previous edge wins over a side that has just arrived on that address. The late side's busy goes low and its write is dropped.
- R6: Busy is released (high) after the first edge at which the addresses differ or either side is disabled. The two busy outputs are never low together.
- R7: While both sides stay enabled on the same unchanged address, ownership does not change.
- R8: A losing side that reads the contested word keeps its read data frozen. The word it shows is the one from the first cycle of the collision, even while the owner writes. It updates on the first edge after busy clears.
- R9: In slave mode (MASTER_MODE = 0), a side's write is dropped while its busy input is low, and both busy outputs stay high.
- R10: In master mode the busy inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_en_ni | input | 1 | Left enable, active low |
| l_we_ni | input | 1 | Left write select, low = write |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_addr_i | input | 11 | Left address |
| l_wdata_i | input | 8 | Left write data |
| l_busy_ni | input | 1 | Left busy input, active low (slave mode) |
| l_rdata_o | output | 8 | Left read data |
| l_busy_no | output | 1 | Left busy output, active low |
| r_en_ni | input | 1 | Right enable, active low |
| r_we_ni | input | 1 | Right write select, low = write |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_addr_i | input | 11 | Right address |
| r_wdata_i | input | 8 | Right write data |
| r_busy_ni | input | 1 | Right busy input, active low (slave mode) |
| r_rdata_o | output | 8 | Right read data |
| r_busy_no | output | 1 | Right busy output, active low |

## Verification
The bench aims at the cases where priority is easy to get wrong. Simultaneous arrival must favour left, so a design without a tie rule would flag both sides or neither. A late arrival must lose to a stable holder, so a design that always favours left would hand the word to the wrong side. An owner that keeps writing while the loser keeps reading is also covered: a design without the freeze would leak the owner's new data to the loser mid-collision. Random traffic confined to four addresses, with busy inputs toggling, catches writes that slip through, busy flags that stay stuck after release, and a master that listens to its busy inputs.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpc_store.sv
module dpc_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              l_wr_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              r_wr_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic [DATA_W-1:0] r_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // right first so that left lands last on a shared address
  always_ff @(posedge clk_i) begin
    if (r_wr_i) mem_q[r_addr_i] <= r_wdata_i;
    if (l_wr_i) mem_q[l_addr_i] <= l_wdata_i;
  end

  assign l_rdata_o = mem_q[l_addr_i];
  assign r_rdata_o = mem_q[r_addr_i];
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
  import dpc_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter bit MASTER_MODE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_act_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_busy_ni,
  input  logic              r_act_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_busy_ni,
  output logic              l_lose_o,
  output logic              r_lose_o,
  output logic              l_busy_no,
  output logic              r_busy_no
);
  if (MASTER_MODE) begin : g_master
    logic              l_act_q, r_act_q;
    logic [ADDR_W-1:0] l_addr_q, r_addr_q;
    owner_e            owner_q, owner_d;
    logic              l_busy_q, r_busy_q;
    logic              col, l_held, r_held;
    logic              unused_busy_in;

    assign unused_busy_in = l_busy_ni ^ r_busy_ni;

    assign col    = l_act_i & r_act_i & (l_addr_i == r_addr_i);
    assign l_held = l_act_i & l_act_q & (l_addr_i == l_addr_q);
    assign r_held = r_act_i & r_act_q & (r_addr_i == r_addr_q);

    always_comb begin
      if (!col)                                        owner_d = OWN_NONE;
      else if (owner_q != OWN_NONE && l_held && r_held) owner_d = owner_q;
      else if (r_held && !l_held)                      owner_d = OWN_RIGHT;
      else                                             owner_d = OWN_LEFT;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        l_act_q  <= 1'b0;
        r_act_q  <= 1'b0;
        l_addr_q <= '0;
        r_addr_q <= '0;
        owner_q  <= OWN_NONE;
        l_busy_q <= 1'b1;
        r_busy_q <= 1'b1;
      end else begin
        l_act_q  <= l_act_i;
        r_act_q  <= r_act_i;
        l_addr_q <= l_addr_i;
        r_addr_q <= r_addr_i;
        owner_q  <= owner_d;
        l_busy_q <= (owner_d != OWN_RIGHT);
        r_busy_q <= (owner_d != OWN_LEFT);
      end
    end

    assign l_lose_o  = (owner_d == OWN_RIGHT);
    assign r_lose_o  = (owner_d == OWN_LEFT);
    assign l_busy_no = l_busy_q;
    assign r_busy_no = r_busy_q;

    p_one_loser_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (l_busy_q | r_busy_q));
    p_fell_needs_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(l_busy_q) || $fell(r_busy_q)) |->
        $past(l_act_i && r_act_i && (l_addr_i == r_addr_i)));
    p_keep_owner_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!r_busy_q && col && l_held && r_held) |=> !r_busy_q);
    p_tie_left_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (col && !l_held && !r_held) |=> (!r_busy_q && l_busy_q));
    p_stable_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (col && r_held && !l_held) |=> (!l_busy_q && r_busy_q));
  end else begin : g_slave
    logic unused_act;
    assign unused_act = l_act_i ^ r_act_i ^ (^l_addr_i) ^ (^r_addr_i) ^ clk_i ^ rst_ni;
    assign l_lose_o  = ~l_busy_ni;
    assign r_lose_o  = ~r_busy_ni;
    assign l_busy_no = 1'b1;
    assign r_busy_no = 1'b1;
  end
endmodule

// File: rtl/dpc_port.sv
module dpc_port #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lose_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              act_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              lose_q, rd_q, rd_now, freeze;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rdata_q;

  assign act_o  = ~en_ni;
  assign rd_now = ~en_ni & we_ni;
  assign wr_o   = ~en_ni & ~we_ni & ~lose_i;
  // loser keeps the word it saw when the collision began
  assign freeze = lose_i & lose_q & rd_now & rd_q & (addr_i == addr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lose_q  <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      rdata_q <= '0;
    end else begin
      lose_q <= lose_i;
      rd_q   <= rd_now;
      addr_q <= addr_i;
      if (rd_now && !freeze) rdata_q <= mem_rdata_i;
    end
  end

  assign rdata_o = oe_ni ? '0 : rdata_q;

  p_hold_rdata_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lose_i && lose_q && rd_now && rd_q && (addr_i == addr_q)) |=> $stable(rdata_q));
  p_loser_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lose_i |-> !wr_o);
endmodule

// File: rtl/dpc_arbiter_top.sv
module dpc_arbiter_top #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter bit MASTER_MODE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_en_ni,
  input  logic              l_we_ni,
  input  logic              l_oe_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_busy_ni,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_busy_no,
  input  logic              r_en_ni,
  input  logic              r_we_ni,
  input  logic              r_oe_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              r_busy_ni,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_busy_no
);
  logic              l_act, r_act, l_lose, r_lose, l_wr, r_wr;
  logic [DATA_W-1:0] l_mem_rd, r_mem_rd;

  dpc_arbiter #(.ADDR_W(ADDR_W), .MASTER_MODE(MASTER_MODE)) u_arb (
    .clk_i, .rst_ni,
    .l_act_i(l_act), .l_addr_i, .l_busy_ni,
    .r_act_i(r_act), .r_addr_i, .r_busy_ni,
    .l_lose_o(l_lose), .r_lose_o(r_lose),
    .l_busy_no, .r_busy_no
  );

  dpc_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lport (
    .clk_i, .rst_ni, .en_ni(l_en_ni), .we_ni(l_we_ni), .oe_ni(l_oe_ni),
    .addr_i(l_addr_i), .lose_i(l_lose), .mem_rdata_i(l_mem_rd),
    .act_o(l_act), .wr_o(l_wr), .rdata_o(l_rdata_o)
  );

  dpc_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rport (
    .clk_i, .rst_ni, .en_ni(r_en_ni), .we_ni(r_we_ni), .oe_ni(r_oe_ni),
    .addr_i(r_addr_i), .lose_i(r_lose), .mem_rdata_i(r_mem_rd),
    .act_o(r_act), .wr_o(r_wr), .rdata_o(r_rdata_o)
  );

  dpc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i,
    .l_wr_i(l_wr), .l_addr_i, .l_wdata_i,
    .r_wr_i(r_wr), .r_addr_i, .r_wdata_i,
    .l_rdata_o(l_mem_rd), .r_rdata_o(r_mem_rd)
  );

  if (MASTER_MODE) begin : g_chk_master
    p_no_shared_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(l_wr && r_wr && (l_addr_i == r_addr_i)));
  end else begin : g_chk_slave
    p_slave_busy_gates_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!l_busy_ni |-> !l_wr) and (!r_busy_ni |-> !r_wr));
  end
endmodule

// File: tb/dpc_arbiter_top_test.sv
`timescale 1ns/1ps
module dpc_arbiter_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // master under test
  logic        l_en_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b0, l_bin = 1'b1;
  logic        r_en_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b0, r_bin = 1'b1;
  logic [10:0] l_addr = '0, r_addr = '0;
  logic [7:0]  l_wd = '0, r_wd = '0;
  logic [7:0]  l_rd, r_rd;
  logic        l_busy_n, r_busy_n;

  dpc_arbiter_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_en_ni(l_en_n), .l_we_ni(l_we_n), .l_oe_ni(l_oe_n), .l_addr_i(l_addr),
    .l_wdata_i(l_wd), .l_busy_ni(l_bin), .l_rdata_o(l_rd), .l_busy_no(l_busy_n),
    .r_en_ni(r_en_n), .r_we_ni(r_we_n), .r_oe_ni(r_oe_n), .r_addr_i(r_addr),
    .r_wdata_i(r_wd), .r_busy_ni(r_bin), .r_rdata_o(r_rd), .r_busy_no(r_busy_n)
  );

  // slave variant
  logic        s_l_en_n = 1'b1, s_l_we_n = 1'b1, s_l_bin = 1'b1;
  logic [10:0] s_l_addr = '0;
  logic [7:0]  s_l_wd = '0;
  logic [7:0]  s_l_rd, s_r_rd;
  logic        s_l_busy_n, s_r_busy_n;

  dpc_arbiter_top #(.MASTER_MODE(1'b0)) uut_slave (
    .clk_i(clk), .rst_ni(rst_n),
    .l_en_ni(s_l_en_n), .l_we_ni(s_l_we_n), .l_oe_ni(1'b0), .l_addr_i(s_l_addr),
    .l_wdata_i(s_l_wd), .l_busy_ni(s_l_bin), .l_rdata_o(s_l_rd), .l_busy_no(s_l_busy_n),
    .r_en_ni(1'b1), .r_we_ni(1'b1), .r_oe_ni(1'b0), .r_addr_i(11'd0),
    .r_wdata_i(8'd0), .r_busy_ni(1'b1), .r_rdata_o(s_r_rd), .r_busy_no(s_r_busy_n)
  );

  // reference state
  logic [7:0]  ref_mem [2048];
  logic [1:0]  own_q = 2'd0;           // 0 none, 1 left, 2 right
  logic        pl_act = 1'b0, pr_act = 1'b0, pl_lose = 1'b0, pr_lose = 1'b0;
  logic        pl_rd = 1'b0, pr_rd = 1'b0;
  logic [10:0] pl_addr = '0, pr_addr = '0;
  logic [7:0]  exp_l = '0, exp_r = '0;
  logic        exp_lb = 1'b1, exp_rb = 1'b1;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] next_owner(input logic col, input logic lh, input logic rh,
                                           input logic [1:0] prev);
    if (!col) return 2'd0;
    if (prev != 2'd0 && lh && rh) return prev;
    if (rh && !lh) return 2'd2;
    return 2'd1;
  endfunction

  task automatic cycle();
    logic la, ra, col, lh, rh, ll, rl, lrd, rrd, lfr, rfr;
    logic [1:0] own;
    @(posedge clk);
    la  = !l_en_n;  ra = !r_en_n;
    col = la && ra && (l_addr == r_addr);
    lh  = la && pl_act && (l_addr == pl_addr);
    rh  = ra && pr_act && (r_addr == pr_addr);
    own = next_owner(col, lh, rh, own_q);
    ll  = (own == 2'd2);  rl = (own == 2'd1);
    lrd = la && l_we_n;   rrd = ra && r_we_n;
    lfr = ll && pl_lose && lrd && pl_rd && (l_addr == pl_addr);
    rfr = rl && pr_lose && rrd && pr_rd && (r_addr == pr_addr);
    if (lrd && !lfr) exp_l = ref_mem[l_addr];
    if (rrd && !rfr) exp_r = ref_mem[r_addr];
    if (ra && !r_we_n && !rl) ref_mem[r_addr] = r_wd;
    if (la && !l_we_n && !ll) ref_mem[l_addr] = l_wd;
    exp_lb = !ll;  exp_rb = !rl;
    own_q = own;  pl_act = la;  pr_act = ra;  pl_addr = l_addr;  pr_addr = r_addr;
    pl_lose = ll;  pr_lose = rl;  pl_rd = lrd;  pr_rd = rrd;
    #2;
    check("R4/R5/R6 left busy",  {7'd0, l_busy_n}, {7'd0, exp_lb});
    check("R4/R5/R6 right busy", {7'd0, r_busy_n}, {7'd0, exp_rb});
    check("R2/R3/R8 left rdata",  l_rd, l_oe_n ? 8'h00 : exp_l);
    check("R2/R3/R8 right rdata", r_rd, r_oe_n ? 8'h00 : exp_r);
  endtask

  function automatic logic [10:0] pool(input int k);
    case (k & 3)
      0: return 11'h000;
      1: return 11'h001;
      2: return 11'h7FE;
      default: return 11'h7FF;
    endcase
  endfunction

  task automatic idle();
    l_en_n = 1'b1; r_en_n = 1'b1; l_we_n = 1'b1; r_we_n = 1'b1;
    l_oe_n = 1'b0; r_oe_n = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    #1;
    check("R1 left busy reset",  {7'd0, l_busy_n}, 8'h01);
    check("R1 right busy reset", {7'd0, r_busy_n}, 8'h01);
    check("R1 left rdata reset", l_rd, 8'h00);
    check("R1 slave busy reset", {7'd0, s_l_busy_n}, 8'h01);

    // preload pool from the left side
    for (int k = 0; k < 4; k++) begin
      l_en_n = 1'b0; l_we_n = 1'b0; l_addr = pool(k); l_wd = 8'h10 + 8'(k * 17);
      cycle();
    end
    idle(); cycle();

    // shared read of one word, simultaneous arrival
    l_en_n = 1'b0; r_en_n = 1'b0; l_addr = 11'h7FF; r_addr = 11'h7FF;
    cycle();
    check("R2 shared read left",  l_rd, 8'h43);
    check("R2 shared read right", r_rd, 8'h43);
    check("R4 tie right busy", {7'd0, r_busy_n}, 8'h00);
    check("R4 tie left free",  {7'd0, l_busy_n}, 8'h01);
    idle(); cycle();
    check("R6 release on disable", {7'd0, r_busy_n}, 8'h01);

    // tie with both writing: right write dropped
    l_en_n = 1'b0; r_en_n = 1'b0; l_we_n = 1'b0; r_we_n = 1'b0;
    l_addr = 11'h000; r_addr = 11'h000; l_wd = 8'hC1; r_wd = 8'hC2;
    cycle();
    idle(); l_en_n = 1'b0; l_addr = 11'h000; cycle();
    check("R4 left write kept on tie", l_rd, 8'hC1);
    idle(); cycle();

    // right stable first, left arrives late with a write
    r_en_n = 1'b0; r_addr = 11'h001; cycle();
    l_en_n = 1'b0; l_we_n = 1'b0; l_addr = 11'h001; l_wd = 8'h5A; cycle();
    check("R5 late left busy",   {7'd0, l_busy_n}, 8'h00);
    check("R5 early right free", {7'd0, r_busy_n}, 8'h01);
    l_en_n = 1'b1; l_we_n = 1'b1; cycle();
    check("R5 late write dropped", r_rd, 8'h21);

    // owner writes while loser reads: loser frozen
    idle(); r_en_n = 1'b0; r_we_n = 1'b0; r_addr = 11'h7FE; r_wd = 8'h66; cycle();
    l_en_n = 1'b0; l_addr = 11'h7FE; r_wd = 8'h99; cycle();
    check("R5 left loses to holder", {7'd0, l_busy_n}, 8'h00);
    check("R8 loser sees pre-write word", l_rd, 8'h66);
    r_wd = 8'hAB; cycle();
    check("R8 loser frozen", l_rd, 8'h66);
    check("R7 owner kept", {7'd0, l_busy_n}, 8'h00);
    r_en_n = 1'b1; r_we_n = 1'b1; cycle();
    check("R6 busy cleared", {7'd0, l_busy_n}, 8'h01);
    check("R8 update after release", l_rd, 8'hAB);
    l_oe_n = 1'b1; cycle();
    check("R3 output disabled", l_rd, 8'h00);

    // busy inputs ignored by master
    idle(); l_bin = 1'b0; r_bin = 1'b0;
    l_en_n = 1'b0; l_we_n = 1'b0; l_addr = 11'h000; l_wd = 8'h5C; cycle();
    l_we_n = 1'b1; cycle();
    check("R10 write with busy input low", l_rd, 8'h5C);

    // slave variant
    idle(); l_bin = 1'b1; r_bin = 1'b1;
    s_l_en_n = 1'b0; s_l_we_n = 1'b0; s_l_addr = 11'h005; s_l_wd = 8'h22; s_l_bin = 1'b1; cycle();
    s_l_wd = 8'h33; s_l_bin = 1'b0; cycle();
    check("R9 slave busy out high", {7'd0, s_l_busy_n}, 8'h01);
    check("R9 slave busy out right high", {7'd0, s_r_busy_n}, 8'h01);
    s_l_we_n = 1'b1; s_l_bin = 1'b1; cycle();
    check("R9 gated write dropped", s_l_rd, 8'h22);
    s_l_en_n = 1'b1;

    // random traffic on a small address pool
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 2) begin
        l_en_n = ($urandom % 4 == 0); l_we_n = $urandom % 2;
        l_addr = pool(int'($urandom)); l_wd = 8'($urandom);
      end
      if ($urandom % 2) begin
        r_en_n = ($urandom % 4 == 0); r_we_n = $urandom % 2;
        r_addr = pool(int'($urandom)); r_wd = 8'($urandom);
      end
      l_oe_n = ($urandom % 5 == 0); r_oe_n = ($urandom % 5 == 0);
      l_bin = $urandom % 2; r_bin = $urandom % 2;
      cycle();
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule